// File: doc/BRIEF.md
# DMA Address and Word-Count Register Pair

This block keeps the two bus-programmable registers that steer a DMA transfer engine: a byte address pointing into memory, and a word counter bundled with a transfer direction flag and an enable flag. Software programs the address register in an unusual way. The value written to it is taken from the address lines of the write cycle, not from the data bus. Bit 14 of that write address chooses whether the upper or the lower part of the register is replaced. The part that is not chosen keeps its value.

The counter is loaded from the data bus. It steps once on its own in the cycle that loads it. Later it advances each time the transfer engine pulses its step strobe. The same strobe moves the address forward by one 16-bit word. The engine reads the registers through the output ports. Software can read the counter back through the read-data port.

Top module: `dma_addr_count_regs`

## Requirements
- R1: A bus write whose address bits 19:16 equal 0xD and whose address bit 14 is 1 loads DMA address bits 21:9 from write-address bits 13:1. DMA address bits 8:0 keep their value.
- R2: A bus write whose address bits 19:16 equal 0xD and whose address bit 14 is 0 loads DMA address bits 8:1 from write-address bits 8:1. DMA address bits 21:9 keep their value.
- R3: DMA address bit 0 reads 0 at all times.
- R4: A bus write whose address bits 19:16 equal 0x6 loads three fields from the write data: bits 13:0 into the count, bit 14 into the direction flag, and bit 15 into the enable flag.
- R5: The count shown in the cycle after a count write is the written 14-bit value plus one, modulo 2^14.
- R6: While the read strobe is high and address bits 19:16 equal 0x6, the read data equals the count with bits 15 and 14 forced to 1.
- R7: A step strobe in a cycle with no register write adds 2 to the DMA address (modulo 2^22) and adds 1 to the count (modulo 2^14). The direction and enable flags are left unchanged.
- R8: In a cycle where a bus write hits either register, a step strobe in that same cycle has no effect on either register.
- R9: After reset, the address, count, direction flag and enable flag are all 0.
- R10: Bus writes to any other value of address bits 19:16 change no register. Reads anywhere other than the count window return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Bus write strobe, one cycle per write |
| bus_rd | input | 1 | Bus read strobe |
| bus_addr | input | 24 | Bus address of the current cycle |
| bus_wdata | input | 16 | Bus write data |
| dma_step | input | 1 | Step strobe from the transfer engine |
| dma_addr | output | 22 | Current DMA byte address |
| dma_count | output | 14 | Current word count |
| dma_dir | output | 1 | Transfer direction flag |
| dma_en | output | 1 | DMA enable flag |
| bus_rdata | output | 16 | Read data, valid in the same cycle as the read strobe |

## Verification
The bench builds the block with its default parameters: a 22-bit address, a 14-bit count, and a split between the two address parts at bit 9. At these widths, one upper write and one lower write can put every address bit at 1. A single step then shows the wrap to zero. A count load of 0x3FFE shows the post-write step landing on 0x3FFF, and the next strobe wraps the count. A long pseudo-random run mixes upper writes, lower writes, count writes, foreign writes, reads and strobes. It also hits the collisions between a write and a strobe in the same cycle, and every cycle is compared against a behavioural model.

// File: rtl/dmar_pkg.sv
package dmar_pkg;
  // Which register window the current bus address falls in
  typedef enum logic [1:0] {
    HIT_NONE = 2'd0,
    HIT_ADDR = 2'd1,
    HIT_CNT  = 2'd2
  } dmar_hit_e;
endpackage

// File: rtl/dmar_decode.sv
module dmar_decode
  import dmar_pkg::*;
#(
  parameter int REGION_W    = 4,
  parameter int ADDR_REGION = 13,
  parameter int CNT_REGION  = 6
) (
  input  logic [REGION_W-1:0] region,
  output dmar_hit_e           hit
);
  localparam logic [REGION_W-1:0] ADDR_CODE = REGION_W'(ADDR_REGION);
  localparam logic [REGION_W-1:0] CNT_CODE  = REGION_W'(CNT_REGION);

  always_comb begin
    if (region == ADDR_CODE)     hit = HIT_ADDR;
    else if (region == CNT_CODE) hit = HIT_CNT;
    else                         hit = HIT_NONE;
  end
endmodule

// File: rtl/dmar_addr_reg.sv
module dmar_addr_reg #(
  parameter int BUS_AW  = 24,
  parameter int ADDR_W  = 22,
  parameter int SPLIT   = 9,
  parameter int SEL_BIT = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic              step,
  output logic [ADDR_W-1:0] addr_q
);
  localparam int HI_W = ADDR_W - SPLIT;

  // Bits of the write address that select nothing here
  logic unused_bus_bits;
  assign unused_bus_bits = ^{bus_addr[BUS_AW-1:SEL_BIT+1], bus_addr[0]};

  function automatic logic [ADDR_W-1:0] merge_upper(logic [ADDR_W-1:0] cur,
                                                    logic [BUS_AW-1:0] wa);
    logic [ADDR_W-1:0] r;
    r = cur;
    r[ADDR_W-1:SPLIT] = wa[HI_W:1];
    return r;
  endfunction

  function automatic logic [ADDR_W-1:0] merge_lower(logic [ADDR_W-1:0] cur,
                                                    logic [BUS_AW-1:0] wa);
    logic [ADDR_W-1:0] r;
    r = cur;
    r[SPLIT-1:1] = wa[SPLIT-1:1];
    r[0] = 1'b0;
    return r;
  endfunction

  function automatic logic [ADDR_W-1:0] next_word(logic [ADDR_W-1:0] cur);
    return cur + ADDR_W'(2);
  endfunction

  logic load_upper, load_lower;
  assign load_upper = load &  bus_addr[SEL_BIT];
  assign load_lower = load & ~bus_addr[SEL_BIT];

  always_ff @(posedge clk) begin
    if (!rst_n)          addr_q <= '0;
    else if (load_upper) addr_q <= merge_upper(addr_q, bus_addr);
    else if (load_lower) addr_q <= merge_lower(addr_q, bus_addr);
    else if (step)       addr_q <= next_word(addr_q);
  end

  assert_even_address_R3: assert property (@(posedge clk) disable iff (!rst_n)
    addr_q[0] == 1'b0);

  assert_upper_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
    load_upper |=> (addr_q[SPLIT-1:0] == $past(addr_q[SPLIT-1:0])) &&
                   (addr_q[ADDR_W-1:SPLIT] == $past(bus_addr[HI_W:1])));

  assert_lower_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load_lower |=> (addr_q[ADDR_W-1:SPLIT] == $past(addr_q[ADDR_W-1:SPLIT])) &&
                   (addr_q[SPLIT-1:1] == $past(bus_addr[SPLIT-1:1])));

  assert_word_advance_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load) |=> addr_q == ADDR_W'($past(addr_q) + ADDR_W'(2)));
endmodule

// File: rtl/dmar_count_reg.sv
module dmar_count_reg #(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] wdata,
  input  logic              step,
  output logic [CNT_W-1:0]  count_q,
  output logic              dir_q,
  output logic              en_q
);
  localparam int DIR_BIT = CNT_W;
  localparam int EN_BIT  = CNT_W + 1;

  logic unused_data_bits;
  generate
    if (DATA_W > EN_BIT + 1) begin : g_spare
      assign unused_data_bits = ^wdata[DATA_W-1:EN_BIT+1];
    end else begin : g_nospare
      assign unused_data_bits = 1'b0;
    end
  endgenerate

  function automatic logic [CNT_W-1:0] bump(logic [CNT_W-1:0] v);
    return v + CNT_W'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count_q <= '0;
      dir_q   <= 1'b0;
      en_q    <= 1'b0;
    end else if (load) begin
      count_q <= bump(wdata[CNT_W-1:0]);
      dir_q   <= wdata[DIR_BIT];
      en_q    <= wdata[EN_BIT];
    end else if (step) begin
      count_q <= bump(count_q);
    end
  end

  assert_load_fields_R4: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (dir_q == $past(wdata[DIR_BIT])) && (en_q == $past(wdata[EN_BIT])));

  assert_post_write_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> count_q == CNT_W'($past(wdata[CNT_W-1:0]) + CNT_W'(1)));

  assert_step_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load) |=> (count_q == CNT_W'($past(count_q) + CNT_W'(1))) &&
                        $stable(dir_q) && $stable(en_q));
endmodule

// File: rtl/dma_addr_count_regs.sv
module dma_addr_count_regs
  import dmar_pkg::*;
#(
  parameter int BUS_AW      = 24,
  parameter int DATA_W      = 16,
  parameter int ADDR_W      = 22,
  parameter int CNT_W       = 14,
  parameter int SPLIT       = 9,
  parameter int SEL_BIT     = 14,
  parameter int REGION_LSB  = 16,
  parameter int REGION_W    = 4,
  parameter int ADDR_REGION = 13,
  parameter int CNT_REGION  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              dma_step,
  output logic [ADDR_W-1:0] dma_addr,
  output logic [CNT_W-1:0]  dma_count,
  output logic              dma_dir,
  output logic              dma_en,
  output logic [DATA_W-1:0] bus_rdata
);
  localparam int FILL_W = DATA_W - CNT_W;

  dmar_hit_e hit;

  dmar_decode #(
    .REGION_W   (REGION_W),
    .ADDR_REGION(ADDR_REGION),
    .CNT_REGION (CNT_REGION)
  ) u_decode (
    .region(bus_addr[REGION_LSB +: REGION_W]),
    .hit   (hit)
  );

  // Named events for the assertions
  logic wr_addr_hit, wr_cnt_hit, any_reg_wr, step_ok, rd_cnt_hit;
  assign wr_addr_hit = bus_wr && (hit == HIT_ADDR);
  assign wr_cnt_hit  = bus_wr && (hit == HIT_CNT);
  assign any_reg_wr  = wr_addr_hit || wr_cnt_hit;
  assign step_ok     = dma_step && !any_reg_wr;
  assign rd_cnt_hit  = bus_rd && (hit == HIT_CNT);

  dmar_addr_reg #(
    .BUS_AW (BUS_AW),
    .ADDR_W (ADDR_W),
    .SPLIT  (SPLIT),
    .SEL_BIT(SEL_BIT)
  ) u_addr (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (wr_addr_hit),
    .bus_addr(bus_addr),
    .step    (step_ok),
    .addr_q  (dma_addr)
  );

  dmar_count_reg #(
    .DATA_W(DATA_W),
    .CNT_W (CNT_W)
  ) u_count (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (wr_cnt_hit),
    .wdata  (bus_wdata),
    .step   (step_ok),
    .count_q(dma_count),
    .dir_q  (dma_dir),
    .en_q   (dma_en)
  );

  always_comb begin
    if (rd_cnt_hit) bus_rdata = {{FILL_W{1'b1}}, dma_count};
    else            bus_rdata = '0;
  end

  assert_write_beats_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_addr_hit && dma_step) |=> (dma_count == $past(dma_count)));

  assert_count_write_holds_addr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cnt_hit && dma_step) |=> (dma_addr == $past(dma_addr)));

  assert_foreign_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && (hit == HIT_NONE) && !dma_step) |=>
      $stable(dma_addr) && $stable(dma_count) && $stable(dma_dir) && $stable(dma_en));

  assert_read_fill_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_cnt_hit |-> (bus_rdata[DATA_W-1:CNT_W] == {FILL_W{1'b1}}));

  assert_reset_clear_R9: assert property (@(posedge clk)
    !rst_n |=> (dma_addr == '0) && (dma_count == '0) && !dma_dir && !dma_en);
endmodule

// File: tb/dma_addr_count_regs_test.sv
module dma_addr_count_regs_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [23:0] bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic        dma_step = 1'b0;
  logic [21:0] dma_addr;
  logic [13:0] dma_count;
  logic        dma_dir, dma_en;
  logic [15:0] bus_rdata;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit compare_on = 1'b0;
  bit done = 1'b0;

  // Behavioural reference state
  int m_addr = 0, m_cnt = 0, m_dir = 0, m_en = 0;

  always #5 clk = ~clk;

  dma_addr_count_regs uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .dma_step(dma_step),
    .dma_addr(dma_addr), .dma_count(dma_count), .dma_dir(dma_dir),
    .dma_en(dma_en), .bus_rdata(bus_rdata)
  );

  task automatic chk(input string req, input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at t=%0t", req, actual, expected, $time);
    end
  endtask

  // Reference model: updated from the inputs at every rising edge
  always @(posedge clk) begin
    int region;
    region = (int'(bus_addr) >> 16) & 15;
    if (!rst_n) begin
      m_addr = 0; m_cnt = 0; m_dir = 0; m_en = 0;
    end else if (bus_wr && region == 13) begin
      if (bus_addr[14]) m_addr = (m_addr & 'h1FF) | (((int'(bus_addr) >> 1) & 'h1FFF) << 9);
      else              m_addr = (m_addr & 'h3FFE00) | (int'(bus_addr) & 'h1FE);
    end else if (bus_wr && region == 6) begin
      m_cnt = (int'(bus_wdata & 16'h3FFF) + 1) % 16384;
      m_dir = int'(bus_wdata[14]);
      m_en  = int'(bus_wdata[15]);
    end else if (dma_step) begin
      m_addr = (m_addr + 2) % (1 << 22);
      m_cnt  = (m_cnt + 1) % 16384;
    end
  end

  // Cycle-by-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (compare_on) begin
      int region, exp_rd;
      region = (int'(bus_addr) >> 16) & 15;
      exp_rd = (bus_rd && region == 6) ? ('hC000 | m_cnt) : 0;
      chk("R1 R2 R3 R7 R8 R10 address", int'(dma_addr), m_addr);
      chk("R4 R5 R7 R8 R10 count", int'(dma_count), m_cnt);
      chk("R4 direction", int'(dma_dir), m_dir);
      chk("R4 enable", int'(dma_en), m_en);
      chk("R6 R10 read data", int'(bus_rdata), exp_rd);
    end
  end

  // One bus cycle; starts and ends at a falling edge
  task automatic cyc(input bit wr, input bit rd, input logic [23:0] a,
                     input logic [15:0] d, input bit st);
    #1;
    bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = d; dma_step = st;
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      failures++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset state
    chk("R9 reset address", int'(dma_addr), 0);
    chk("R9 reset count", int'(dma_count), 0);
    chk("R9 reset flags", int'({dma_dir, dma_en}), 0);
    #1 rst_n = 1'b1;
    compare_on = 1'b1;
    @(negedge clk);

    cyc(1, 0, 24'h4D7FFE, 16'h0000, 0);
    chk("R1 upper half all ones", int'(dma_addr), 'h3FFE00);
    cyc(1, 0, 24'h4D01FE, 16'h0000, 0);
    chk("R2 lower half all ones", int'(dma_addr), 'h3FFFFE);
    cyc(0, 0, 24'h000000, 16'h0000, 1);
    chk("R7 address wrap", int'(dma_addr), 0);
    chk("R7 count step", int'(dma_count), 1);
    cyc(1, 0, 24'h4D4002, 16'h0000, 0);
    chk("R1 upper load keeps lower", int'(dma_addr), 'h200);
    cyc(1, 0, 24'h4D0155, 16'h0000, 0);
    chk("R2 R3 lower load, bit 0 clear", int'(dma_addr), 'h354);
    cyc(1, 0, 24'h46ABCD, 16'hFFFE, 0);
    chk("R5 post-write step", int'(dma_count), 'h3FFF);
    chk("R4 flags loaded", int'({dma_dir, dma_en}), 3);
    cyc(0, 1, 24'h460000, 16'h0000, 0);
    chk("R6 read format", int'(bus_rdata), 'hFFFF);
    cyc(0, 0, 24'h000000, 16'h0000, 1);
    chk("R7 count wrap", int'(dma_count), 0);
    chk("R7 flags kept", int'({dma_dir, dma_en}), 3);
    cyc(1, 0, 24'h460000, 16'h4005, 1);
    chk("R8 count write beats step", int'(dma_count), 6);
    chk("R8 address held", int'(dma_addr), 'h356);
    cyc(1, 0, 24'h4D4000, 16'h0000, 1);
    chk("R8 address write beats step", int'(dma_count), 6);
    cyc(1, 0, 24'h43FFFF, 16'hFFFF, 0);
    chk("R10 foreign write address", int'(dma_addr), 'h156);
    chk("R10 foreign write count", int'(dma_count), 6);
    cyc(0, 1, 24'h4D0000, 16'h0000, 0);
    chk("R10 read outside count window", int'(bus_rdata), 0);

    for (int i = 0; i < 600; i++) begin
      int sel;
      logic [23:0] a;
      sel = $urandom_range(0, 5);
      a = 24'($urandom);
      case (sel)
        0: a[19:16] = 4'hD;
        1: a[19:16] = 4'h6;
        2: a[19:16] = 4'h6;
        default: ;
      endcase
      cyc(($urandom_range(0, 2) == 0), ($urandom_range(0, 1) == 1), a,
          16'($urandom), ($urandom_range(0, 1) == 1));
    end

    cyc(0, 0, 24'h000000, 16'h0000, 0);
    finish_run();
  end
endmodule